// File: doc/BRIEF.md
# Streaming CRC-6 Engine with Runtime Generator

The engine computes a 6-bit cyclic redundancy check over every 32-bit word it receives. Each word is processed on its own. The generator polynomial does not come from a fixed constant. It is read from an input port together with each word, so neighbouring words in one stream may be checked against different generators. Words enter on a valid/ready slave port, and results leave on a valid/ready master port in the same order.

The division runs one bit at a time and is unrolled across six register stages. A new word can enter on every clock cycle, and its check value appears a fixed six cycles later. Back-pressure rule: when the consumer holds `res_ready` low while `res_valid` is high, every stage freezes and `word_ready` drops, so no word or result is dropped. When the output stage is empty, the engine keeps accepting words whatever the state of `res_ready`. A word transfers on a rising edge where `word_valid` and `word_ready` are both high. A result transfers on a rising edge where `res_valid` and `res_ready` are both high.

Top module: `crc6_stream`

## Requirements
- R1: The CRC register starts at zero for each word. The 32 data bits are consumed most significant first. For each bit, the feedback is the register's bit 5 XOR the data bit. The register shifts left by one with a zero entering at bit 0, and it is XORed with the 6-bit polynomial when the feedback is 1. The polynomial port omits the implicit x^6 term.
- R2: An all-zero data word gives a CRC of zero for any polynomial, and a zero polynomial gives a CRC of zero for any data word.
- R3: A word accepted on the clock edge that ends cycle c has its result on `res_valid`/`res_crc` in cycle c+6, and `res_valid` stays low in cycles c+1 through c+5.
- R4: Words can be accepted on consecutive cycles (initiation interval 1), and results come out in acceptance order.
- R5: The polynomial is captured with its word, so a change on `poly` only affects words accepted afterwards.
- R6: While `res_valid` is high and `res_ready` is low, `res_crc` and `res_valid` hold their values and `word_ready` is low. No accepted word is lost.
- R7: Reset is asynchronous and active low. While it is asserted and after it is released, `res_valid` is low and `word_ready` is high, and no result from a word accepted before the reset ever appears.
- R8: `word_ready` is high whenever `res_valid` is low, even if `res_ready` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| word_valid | input | 1 | Input word present |
| word_ready | output | 1 | Engine can take a word this cycle |
| word_data | input | 32 | Data word to check |
| poly | input | 6 | Generator polynomial without the x^6 term |
| res_valid | output | 1 | Result present |
| res_ready | input | 1 | Consumer takes the result this cycle |
| res_crc | output | 6 | CRC of the word |

## Verification
A corrupted partial remainder in any stage gives a wrong `res_crc` for exactly that word. It shows up at most six cycles after the word enters, and the result on either side of it is not affected. A stage valid bit that is lost or duplicated breaks the result order and count. This is visible at the first result after the fault, through a mismatch with the expected sequence or a final count that differs from the number of words sent. A polynomial that is sampled at the wrong time only shows when the generator changes between consecutive words, so the stream tests switch it on every word.

// File: rtl/crc6_pkg.sv
package crc6_pkg;
  localparam int DATA_W = 32;
  localparam int CRC_W  = 6;

  typedef struct packed {
    logic              valid;
    logic [CRC_W-1:0]  poly;
    logic [CRC_W-1:0]  crc;
    logic [DATA_W-1:0] data;
  } stage_t;

  // bits handled by stage idx when total bits are split over n stages
  function automatic int stage_bits(input int idx, input int total, input int n);
    stage_bits = total / n + ((idx < (total % n)) ? 1 : 0);
  endfunction
endpackage

// File: rtl/crc6_flow_ctl.sv
module crc6_flow_ctl (
  input  logic last_valid,
  input  logic sink_ready,
  output logic advance,
  output logic src_ready
);
  // all stages move together unless a held result is refused
  assign advance   = !last_valid || sink_ready;
  assign src_ready = advance;
endmodule

// File: rtl/crc6_stage.sv
module crc6_stage
  import crc6_pkg::*;
#(
  parameter int NBITS = 6
) (
  input  logic   clk,
  input  logic   rst_n,
  input  logic   advance,
  input  stage_t d,
  output stage_t q
);
  stage_t nxt;

  always_comb begin
    logic [CRC_W-1:0]  c;
    logic [DATA_W-1:0] w;
    logic              fb;
    c = d.crc;
    w = d.data;
    for (int k = 0; k < NBITS; k++) begin
      fb = c[CRC_W-1] ^ w[DATA_W-1];
      c  = {c[CRC_W-2:0], 1'b0} ^ ({CRC_W{fb}} & d.poly);
      w  = {w[DATA_W-2:0], 1'b0};
    end
    nxt.valid = d.valid;
    nxt.poly  = d.poly;
    nxt.crc   = c;
    nxt.data  = w;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       q <= '0;
    else if (advance) q <= nxt;
  end
endmodule

// File: rtl/crc6_stream.sv
module crc6_stream
  import crc6_pkg::*;
#(
  parameter int STAGES = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              word_valid,
  output logic              word_ready,
  input  logic [DATA_W-1:0] word_data,
  input  logic [CRC_W-1:0]  poly,
  output logic              res_valid,
  input  logic              res_ready,
  output logic [CRC_W-1:0]  res_crc
);
  stage_t st [0:STAGES];
  logic   advance;

  crc6_flow_ctl u_flow (
    .last_valid (st[STAGES].valid),
    .sink_ready (res_ready),
    .advance    (advance),
    .src_ready  (word_ready)
  );

  always_comb begin
    st[0].valid = word_valid;
    st[0].poly  = poly;
    st[0].crc   = '0;
    st[0].data  = word_data;
  end

  for (genvar i = 0; i < STAGES; i++) begin : g_stage
    localparam int NB = stage_bits(i, DATA_W, STAGES);
    crc6_stage #(.NBITS(NB)) u_stage (
      .clk     (clk),
      .rst_n   (rst_n),
      .advance (advance),
      .d       (st[i]),
      .q       (st[i+1])
    );
  end

  assign res_valid = st[STAGES].valid;
  assign res_crc   = st[STAGES].crc;
endmodule

// File: rtl/crc6_stream_chk.sv
module crc6_stream_chk #(
  parameter int STAGES = 6
) (
  input logic       clk,
  input logic       rst_n,
  input logic       word_valid,
  input logic       word_ready,
  input logic       res_valid,
  input logic       res_ready,
  input logic [5:0] res_crc
);
  localparam int OW = $clog2(STAGES + 2) + 1;
  logic [OW-1:0] occ;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) occ <= '0;
    else occ <= occ + OW'(word_valid && word_ready) - OW'(res_valid && res_ready);
  end

  // R6
  stall_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (res_valid && !res_ready) |=> (res_valid && $stable(res_crc)));

  // R6
  no_accept_stalled_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (res_valid && !res_ready) |-> !word_ready);

  // R8
  accept_when_empty_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !res_valid |-> word_ready);

  // R4
  occupancy_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    occ <= OW'(STAGES));

  // R7
  no_phantom_chk: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid |-> (occ != '0));
endmodule

bind crc6_stream crc6_stream_chk #(.STAGES(STAGES)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .word_valid (word_valid),
  .word_ready (word_ready),
  .res_valid  (res_valid),
  .res_ready  (res_ready),
  .res_crc    (res_crc)
);

// File: tb/sim_crc6_stream.sv
module sim_crc6_stream;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        word_valid = 1'b0;
  logic        word_ready;
  logic [31:0] word_data = '0;
  logic [5:0]  poly = '0;
  logic        res_valid;
  logic        res_ready = 1'b1;
  logic [5:0]  res_crc;

  int checks = 0;
  int errors = 0;

  always #10 clk = ~clk;

  crc6_stream u0 (
    .clk(clk), .rst_n(rst_n), .word_valid(word_valid), .word_ready(word_ready),
    .word_data(word_data), .poly(poly), .res_valid(res_valid),
    .res_ready(res_ready), .res_crc(res_crc)
  );

  // {data, poly, expected crc}, worked out by hand from R1/R2
  localparam logic [43:0] VEC [0:8] = '{
    {32'h0000_0000, 6'h2F, 6'h00},
    {32'hDEAD_BEEF, 6'h00, 6'h00},
    {32'h0000_0001, 6'h2F, 6'h2F},
    {32'h0000_0001, 6'h03, 6'h03},
    {32'h0000_0002, 6'h03, 6'h06},
    {32'h0000_0020, 6'h03, 6'h23},
    {32'h0000_0040, 6'h03, 6'h05},
    {32'h0000_0041, 6'h03, 6'h06},
    {32'h0000_0002, 6'h21, 6'h23}
  };

  function automatic logic [5:0] ref_crc(input logic [31:0] d, input logic [5:0] p);
    logic [5:0] c;
    logic fb;
    c = '0;
    for (int k = 31; k >= 0; k--) begin
      fb = c[5] ^ d[k];
      c  = {c[4:0], 1'b0};
      if (fb) c = c ^ p;
    end
    return c;
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // sends one word, checks R3 latency and the value
  task automatic one_word(input string req, input logic [31:0] d, input logic [5:0] p,
                          input logic [5:0] exp);
    @(negedge clk);
    word_valid = 1'b1; word_data = d; poly = p;
    @(negedge clk);
    word_valid = 1'b0; poly = ~p;
    for (int k = 1; k < 6; k++) begin
      if (res_valid) check("R3 early valid", 1, 0);
      @(negedge clk);
    end
    check("R3 valid at cycle 6", res_valid, 1);
    check(req, res_crc, exp);
  endtask

  // stream with per-word polynomial change and a back-pressure pattern
  task automatic run_stream(input int n, input int seed, input bit bp);
    logic [31:0] dq [0:31];
    logic [5:0]  pq [0:31];
    int tx = 0, rx = 0, cyc = 0;
    logic [5:0] held = '0;
    bit was_stalled = 0;
    for (int k = 0; k < n; k++) begin
      dq[k] = 32'h9E37_79B9 * (k + seed) ^ (k << 7);
      pq[k] = 6'((k * 13 + seed) | 1);
    end
    while ((rx < n) && (cyc < 400)) begin
      @(negedge clk);
      res_ready  = bp ? ((cyc % 5) < 2 || (cyc % 7) == 3) : 1'b1;
      word_valid = (tx < n);
      word_data  = (tx < n) ? dq[tx] : '0;
      poly       = (tx < n) ? pq[tx] : 6'h3F;
      #1;
      if (was_stalled) begin
        check("R6 held result", res_crc, held);
        check("R6 held valid", res_valid, 1);
      end
      if (res_valid && !res_ready) check("R6 ready low when stalled", word_ready, 0);
      if (!res_valid) check("R8 ready when empty", word_ready, 1);
      if (res_valid && res_ready) begin
        check("R4/R5 stream crc", res_crc, ref_crc(dq[rx], pq[rx]));
        rx++;
      end
      was_stalled = res_valid && !res_ready;
      held = res_crc;
      if (word_valid && word_ready) tx++;
      cyc++;
    end
    @(negedge clk);
    word_valid = 1'b0; res_ready = 1'b1;
    check("R6 no lost results", rx, n);
  endtask

  initial begin : watchdog
    repeat (20000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #5;
    check("R7 reset valid low", res_valid, 0);
    check("R7 reset ready high", word_ready, 1);
    repeat (2) @(negedge clk);
    rst_n = 1'b1;

    for (int i = 0; i < 9; i++) begin
      one_word((i < 2) ? "R2 zero case" : "R1 crc vector",
               VEC[i][43:12], VEC[i][11:6], VEC[i][5:0]);
    end

    // R8: empty pipe, consumer not ready, still accepts
    @(negedge clk);
    res_ready = 1'b0;
    #1 check("R8 ready with res_ready low", word_ready, 1);
    res_ready = 1'b1;

    run_stream(24, 3, 1'b0);   // R4 back-to-back
    run_stream(24, 11, 1'b1);  // R6 back-pressure

    // R7: async reset flushes in-flight words
    @(negedge clk);
    word_valid = 1'b1; word_data = 32'h1234_5678; poly = 6'h2B;
    repeat (3) @(negedge clk);
    word_valid = 1'b0;
    #3 rst_n = 1'b0;
    #1 check("R7 async clear valid", res_valid, 0);
    check("R7 async ready", word_ready, 1);
    @(negedge clk);
    rst_n = 1'b1;
    for (int k = 0; k < 8; k++) begin
      @(negedge clk);
      if (res_valid) check("R7 flushed word appeared", 1, 0);
    end
    check("R7 idle after reset", res_valid, 0);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule